// File: doc/BRIEF.md
# Local Interrupt Controller Register File

This block is the register bank of one local interrupt controller. Software reaches it through a simple 32-bit read/write port with a 12-bit byte offset; every register sits on a 16-byte boundary. The bank stores the configuration that the rest of the controller uses: identity, task priority, logical addressing, the spurious-vector and software-enable control, the interrupt command pair, six local vector entries (timer, thermal, performance, two local pins, error) and the timer divide and initial-count values. It applies the write rules of each register as it stores it.

Some words are not held here. The processor priority, the timer current count and the in-service, trigger-mode and request bitmaps come in live from sibling blocks and are only multiplexed onto the read path. A write to the low command word raises a one-cycle send strobe toward the inter-processor logic. A write to the end-of-interrupt word raises a one-cycle strobe toward the priority logic. Any access to an offset outside the decoded set is recorded as an illegal-address error. Errors gather in a hidden accumulator and become visible only when software writes the error status word.

Top module: `lic_regfile`

## Requirements
- R1: After reset the words read as follows. ID is {id_i, 24'h0}. Version is 32'h0005_0014: the maximum entry index is number of entries minus one, in bits 23:16. The destination format word is 32'hFFFF_FFFF. The spurious word is 32'h0000_00FF. Each vector entry is 32'h0001_0000. All other stored words and the visible error status are zero.
- R2: A read is answered on the clock edge that samples it. rd_valid_o is high for exactly that cycle and rd_data_o holds the word until the next read.
- R3: A read at 0x0A0 returns {24'h0, prio_i}. A read at 0x390 returns count_i.
- R4: A read at 0x100+16n, 0x180+16n or 0x200+16n (n = 0..7) returns bits 32n+31:32n of isr_i, tmr_i or irr_i respectively.
- R5: A read or write at an offset with bits 3:0 not zero, or at any undecoded offset, sets error bit 7 in the accumulator. Such a read returns zero.
- R6: Writes to ID (0x020) and version (0x030) change nothing and raise no error.
- R7: Writes to 0x0A0, 0x100–0x270 and 0x390 are illegal. They set error bit 7 and change nothing.
- R8: A write to the error status word (0x280) discards its data. The visible word takes the accumulated bits, which include any pulses on err_evt_i, and the accumulator clears. The visible word changes at no other time.
- R9: A write to entry k (0x320+16k, in the order timer, thermal, performance, pin 0, pin 1, error) is ANDed with its mask. The masks are 0x000300FF, 0x000107FF, 0x000107FF, 0x0001A7FF, 0x0001A7FF and 0x000100FF. Bit 16 is forced to one when spurious bit 8 (software enable) is clear.
- R10: A spurious write (0x0F0) keeps bits 9:0. If the written bit 8 is zero, bit 16 of all six entries is set.
- R11: Writes keep only certain bits, and tpr_o, timer_div_o and timer_init_o follow the stored words:
  - destination format (0x0E0) keeps bits 31:28 and forces bits 27:0 to one;
  - logical destination (0x0D0) keeps bits 31:24;
  - task priority (0x080) keeps bits 7:0;
  - timer divide (0x3E0) keeps bits 3, 1 and 0;
  - timer initial count (0x380) keeps all 32 bits.
- R12: A write to the high command word (0x310) keeps bits 31:24. A write to the low command word (0x300) keeps the bits in 0x000CCFFF, and ipi_send_o is high for the one cycle after the write edge.
- R13: A write to 0x0B0 stores the data for read-back, and eoi_o is high for the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_i | input | 8 | Instance identifier loaded into ID at reset |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| prio_i | input | 8 | Live processor priority |
| count_i | input | 32 | Live timer current count |
| isr_i | input | 256 | In-service bitmap |
| tmr_i | input | 256 | Trigger-mode bitmap |
| irr_i | input | 256 | Request bitmap |
| err_evt_i | input | 8 | Error pulses from other blocks |
| rd_valid_o | output | 1 | Read answer valid |
| rd_data_o | output | 32 | Read answer |
| ipi_send_o | output | 1 | Command send strobe |
| eoi_o | output | 1 | End-of-interrupt strobe |
| tpr_o | output | 8 | Task priority |
| sw_en_o | output | 1 | Software enable (spurious bit 8) |
| icr_o | output | 64 | Command pair {high, low} |
| lvt_o | output | 192 | Vector entries, entry k in bits 32k+31:32k |
| timer_init_o | output | 32 | Timer initial count |
| timer_div_o | output | 32 | Timer divide word |

## Verification
A wrong decode shows up on the next read, either as the wrong word or as a zero. It also shows up later as an error bit that appears, or fails to appear, in the error status word once that word is flushed. A forced-mask fault stays hidden until the affected entry is read back or until lvt_o is sampled. The visible error word is only meaningful after a flush, so each error scenario flushes twice: once to clear stale bits and once after the stimulus. The strobes are checked in the one cycle after the write and again one cycle later.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int NUM_LVT   = 6;
    localparam int WORD_W    = 32;
    localparam int OFF_W     = 12;
    localparam int VEC_COUNT = 256;
    localparam int ERR_W     = 8;
    localparam int ERR_ILLEGAL = 7;
    localparam logic [7:0] HW_VERSION = 8'h14;
    localparam logic [WORD_W-1:0] VERSION_WORD =
        {8'h00, 8'(NUM_LVT - 1), 8'h00, HW_VERSION};

    typedef enum logic [4:0] {
        K_NONE, K_ID, K_VER, K_TPR, K_PPR, K_EOI, K_LDR, K_DFR, K_SVR,
        K_ISR, K_TMR, K_IRR, K_ESR, K_ICRL, K_ICRH, K_LVT,
        K_TINIT, K_TCUR, K_TDIV
    } reg_kind_e;

    function automatic logic [WORD_W-1:0] lvt_mask(input int idx);
        case (idx)
            0:       return 32'h0003_00FF;
            1, 2:    return 32'h0001_07FF;
            3, 4:    return 32'h0001_A7FF;
            default: return 32'h0001_00FF;
        endcase
    endfunction
endpackage

// File: rtl/lic_decode.sv
module lic_decode
    import lic_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    output reg_kind_e        kind_o,
    output logic [2:0]       sub_o
);
    logic [7:0] idx;
    logic [7:0] lvt_rel;

    assign idx     = off_i[11:4];
    assign lvt_rel = idx - 8'h32;

    always_comb begin
        kind_o = K_NONE;
        sub_o  = idx[2:0];
        if (off_i[3:0] == 4'h0) begin
            case (idx) inside
                8'h02:          kind_o = K_ID;
                8'h03:          kind_o = K_VER;
                8'h08:          kind_o = K_TPR;
                8'h0A:          kind_o = K_PPR;
                8'h0B:          kind_o = K_EOI;
                8'h0D:          kind_o = K_LDR;
                8'h0E:          kind_o = K_DFR;
                8'h0F:          kind_o = K_SVR;
                [8'h10:8'h17]:  kind_o = K_ISR;
                [8'h18:8'h1F]:  kind_o = K_TMR;
                [8'h20:8'h27]:  kind_o = K_IRR;
                8'h28:          kind_o = K_ESR;
                8'h30:          kind_o = K_ICRL;
                8'h31:          kind_o = K_ICRH;
                [8'h32:8'h37]:  begin kind_o = K_LVT; sub_o = lvt_rel[2:0]; end
                8'h38:          kind_o = K_TINIT;
                8'h39:          kind_o = K_TCUR;
                8'h3E:          kind_o = K_TDIV;
                default:        kind_o = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lic_esr.sv
module lic_esr
    import lic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  evt_i,
    input  logic              flush_i,
    output logic [WORD_W-1:0] esr_o
);
    logic [ERR_W-1:0] acc_d, acc_q, vis_d, vis_q;

    always_comb begin
        acc_d = (flush_i ? '0 : acc_q) | evt_i;
        vis_d = flush_i ? acc_q : vis_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            vis_q <= '0;
        end else begin
            acc_q <= acc_d;
            vis_q <= vis_d;
        end
    end

    assign esr_o = {{(WORD_W-ERR_W){1'b0}}, vis_q};

    assert_esr_only_on_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> $stable(esr_o));
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
    import lic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                id_i,
    input  logic                      req_valid_i,
    input  logic                      req_write_i,
    input  logic [OFF_W-1:0]          req_off_i,
    input  logic [WORD_W-1:0]         req_wdata_i,
    input  logic [7:0]                prio_i,
    input  logic [WORD_W-1:0]         count_i,
    input  logic [VEC_COUNT-1:0]      isr_i,
    input  logic [VEC_COUNT-1:0]      tmr_i,
    input  logic [VEC_COUNT-1:0]      irr_i,
    input  logic [ERR_W-1:0]          err_evt_i,
    output logic                      rd_valid_o,
    output logic [WORD_W-1:0]         rd_data_o,
    output logic                      ipi_send_o,
    output logic                      eoi_o,
    output logic [7:0]                tpr_o,
    output logic                      sw_en_o,
    output logic [2*WORD_W-1:0]       icr_o,
    output logic [NUM_LVT*WORD_W-1:0] lvt_o,
    output logic [WORD_W-1:0]         timer_init_o,
    output logic [WORD_W-1:0]         timer_div_o
);
    localparam int SW_EN_BIT = 8;
    localparam int MASK_BIT  = 16;

    typedef struct packed {
        logic [7:0]                     id;
        logic [7:0]                     tpr;
        logic [WORD_W-1:0]              eoi;
        logic [WORD_W-1:0]              ldr;
        logic [WORD_W-1:0]              dfr;
        logic [WORD_W-1:0]              svr;
        logic [WORD_W-1:0]              icr_lo;
        logic [WORD_W-1:0]              icr_hi;
        logic [NUM_LVT-1:0][WORD_W-1:0] lvt;
        logic [WORD_W-1:0]              tinit;
        logic [WORD_W-1:0]              tdiv;
        logic [WORD_W-1:0]              rdata;
        logic                           rvalid;
        logic                           ipi;
        logic                           eoi_pulse;
    } state_t;

    state_t     s_d, s_q, s_rst;
    reg_kind_e  kind;
    logic [2:0] sub;
    logic       illegal_d;
    logic       esr_flush_d;
    logic [WORD_W-1:0] esr_word;
    logic [WORD_W-1:0] lvt_wr_d;

    lic_decode u_decode (
        .off_i  (req_off_i),
        .kind_o (kind),
        .sub_o  (sub)
    );

    lic_esr u_esr (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (err_evt_i | (ERR_W'(illegal_d) << ERR_ILLEGAL)),
        .flush_i (esr_flush_d),
        .esr_o   (esr_word)
    );

    always_comb begin
        s_rst        = '0;
        s_rst.id     = id_i;
        s_rst.dfr    = '1;
        s_rst.svr    = 32'h0000_00FF;
        for (int i = 0; i < NUM_LVT; i++) s_rst.lvt[i] = 32'h0001_0000;
    end

    always_comb begin
        s_d           = s_q;
        s_d.rvalid    = 1'b0;
        s_d.ipi       = 1'b0;
        s_d.eoi_pulse = 1'b0;
        illegal_d     = 1'b0;
        esr_flush_d   = 1'b0;
        lvt_wr_d      = '0;
        for (int i = 0; i < NUM_LVT; i++)
            if (sub == 3'(i)) lvt_wr_d = req_wdata_i & lvt_mask(i);
        if (!s_q.svr[SW_EN_BIT]) lvt_wr_d[MASK_BIT] = 1'b1;

        if (req_valid_i && !req_write_i) begin
            s_d.rvalid = 1'b1;
            case (kind)
                K_ID:    s_d.rdata = {s_q.id, 24'h0};
                K_VER:   s_d.rdata = VERSION_WORD;
                K_TPR:   s_d.rdata = {24'h0, s_q.tpr};
                K_PPR:   s_d.rdata = {24'h0, prio_i};
                K_EOI:   s_d.rdata = s_q.eoi;
                K_LDR:   s_d.rdata = s_q.ldr;
                K_DFR:   s_d.rdata = s_q.dfr;
                K_SVR:   s_d.rdata = s_q.svr;
                K_ISR:   s_d.rdata = isr_i[32*sub +: 32];
                K_TMR:   s_d.rdata = tmr_i[32*sub +: 32];
                K_IRR:   s_d.rdata = irr_i[32*sub +: 32];
                K_ESR:   s_d.rdata = esr_word;
                K_ICRL:  s_d.rdata = s_q.icr_lo;
                K_ICRH:  s_d.rdata = s_q.icr_hi;
                K_LVT: begin
                    s_d.rdata = '0;
                    for (int i = 0; i < NUM_LVT; i++)
                        if (sub == 3'(i)) s_d.rdata = s_q.lvt[i];
                end
                K_TINIT: s_d.rdata = s_q.tinit;
                K_TCUR:  s_d.rdata = count_i;
                K_TDIV:  s_d.rdata = s_q.tdiv;
                default: begin
                    s_d.rdata = '0;
                    illegal_d = 1'b1;
                end
            endcase
        end else if (req_valid_i) begin
            case (kind)
                K_ID, K_VER: ;
                K_TPR:   s_d.tpr = req_wdata_i[7:0];
                K_EOI: begin
                    s_d.eoi       = req_wdata_i;
                    s_d.eoi_pulse = 1'b1;
                end
                K_LDR:   s_d.ldr = req_wdata_i & 32'hFF00_0000;
                K_DFR:   s_d.dfr = req_wdata_i | 32'h0FFF_FFFF;
                K_SVR: begin
                    s_d.svr = req_wdata_i & 32'h0000_03FF;
                    if (!req_wdata_i[SW_EN_BIT])
                        for (int i = 0; i < NUM_LVT; i++) s_d.lvt[i][MASK_BIT] = 1'b1;
                end
                K_ESR:   esr_flush_d = 1'b1;
                K_ICRL: begin
                    s_d.icr_lo = req_wdata_i & 32'h000C_CFFF;
                    s_d.ipi    = 1'b1;
                end
                K_ICRH:  s_d.icr_hi = req_wdata_i & 32'hFF00_0000;
                K_LVT: begin
                    for (int i = 0; i < NUM_LVT; i++)
                        if (sub == 3'(i)) s_d.lvt[i] = lvt_wr_d;
                end
                K_TINIT: s_d.tinit = req_wdata_i;
                K_TDIV:  s_d.tdiv = req_wdata_i & 32'h0000_000B;
                default: illegal_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    assign rd_valid_o   = s_q.rvalid;
    assign rd_data_o    = s_q.rdata;
    assign ipi_send_o   = s_q.ipi;
    assign eoi_o        = s_q.eoi_pulse;
    assign tpr_o        = s_q.tpr;
    assign sw_en_o      = s_q.svr[SW_EN_BIT];
    assign icr_o        = {s_q.icr_hi, s_q.icr_lo};
    assign lvt_o        = s_q.lvt;
    assign timer_init_o = s_q.tinit;
    assign timer_div_o  = s_q.tdiv;

    generate
        for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt_chk
            assert_masked_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !sw_en_o |-> lvt_o[g*WORD_W + MASK_BIT]);
        end
    endgenerate

    assert_ipi_after_icr_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_send_o |-> $past(req_valid_i && req_write_i && req_off_i == 12'h300));

    assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rd_valid_o);

    assert_dfr_reserved_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dfr[27:0] == 28'hFFF_FFFF);

    assert_eoi_after_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |-> $past(req_valid_i && req_write_i && req_off_i == 12'h0B0));
endmodule

// File: tb/lic_regfile_test.sv
`timescale 1ns/1ps
module lic_regfile_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   id_i = 8'h5A;
    logic         req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [11:0]  req_off_i = '0;
    logic [31:0]  req_wdata_i = '0;
    logic [7:0]   prio_i = 8'h3C;
    logic [31:0]  count_i = 32'h0BAD_F00D;
    logic [255:0] isr_i, tmr_i, irr_i;
    logic [7:0]   err_evt_i = '0;
    logic         rd_valid_o, ipi_send_o, eoi_o, sw_en_o;
    logic [31:0]  rd_data_o, timer_init_o, timer_div_o;
    logic [7:0]   tpr_o;
    logic [63:0]  icr_o;
    logic [191:0] lvt_o;

    int n_checks = 0, n_fail = 0;
    logic [31:0] rv;
    logic ipi_snap, eoi_snap;

    lic_regfile uut (.*);

    always #2 clk = ~clk;

    initial begin
        for (int i = 0; i < 8; i++) begin
            isr_i[32*i +: 32] = 32'h1000_0000 + i;
            tmr_i[32*i +: 32] = 32'h2000_0000 + i;
            irr_i[32*i +: 32] = 32'h3000_0000 + i;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] off, output logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1; req_write_i = 0; req_off_i = off;
        @(posedge clk); #1;
        d = rd_data_o;
        chk("R2 valid", 32'(rd_valid_o), 1);
        @(negedge clk);
        req_valid_i = 0;
        @(posedge clk); #1;
        chk("R2 drop", 32'(rd_valid_o), 0);
    endtask

    task automatic wr(logic [11:0] off, logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1; req_write_i = 1; req_off_i = off; req_wdata_i = d;
        @(posedge clk); #1;
        ipi_snap = ipi_send_o; eoi_snap = eoi_o;
        @(negedge clk);
        req_valid_i = 0; req_write_i = 0;
    endtask

    task automatic flush_esr(output logic [31:0] d);
        wr(12'h280, 32'hFFFF_FFFF);
        rd(12'h280, d);
    endtask

    task automatic t_reset;
        rd(12'h020, rv); chk("R1 id", rv, 32'h5A00_0000);
        rd(12'h030, rv); chk("R1 version", rv, 32'h0005_0014);
        rd(12'h0E0, rv); chk("R1 dfr", rv, 32'hFFFF_FFFF);
        rd(12'h0F0, rv); chk("R1 svr", rv, 32'h0000_00FF);
        rd(12'h350, rv); chk("R1 lvt pin0", rv, 32'h0001_0000);
        rd(12'h080, rv); chk("R1 tpr", rv, 0);
        rd(12'h280, rv); chk("R1 esr", rv, 0);
        chk("R1 ipi idle", 32'(ipi_send_o), 0);
    endtask

    task automatic t_live;
        rd(12'h0A0, rv); chk("R3 ppr", rv, 32'h0000_003C);
        rd(12'h390, rv); chk("R3 ccr", rv, 32'h0BAD_F00D);
        rd(12'h100, rv); chk("R4 isr0", rv, 32'h1000_0000);
        rd(12'h1F0, rv); chk("R4 tmr7", rv, 32'h2000_0007);
        rd(12'h230, rv); chk("R4 irr3", rv, 32'h3000_0003);
    endtask

    task automatic t_illegal;
        flush_esr(rv); flush_esr(rv);
        chk("R5 esr clean", rv, 0);
        rd(12'h040, rv); chk("R5 undecoded read zero", rv, 0);
        flush_esr(rv); chk("R5 undecoded read error", rv, 32'h80);
        flush_esr(rv); chk("R8 accumulator cleared", rv, 0);
        rd(12'h024, rv); chk("R5 unaligned read zero", rv, 0);
        wr(12'h3F0, 32'h1);
        flush_esr(rv); chk("R5 unaligned+undecoded error", rv, 32'h80);
    endtask

    task automatic t_readonly;
        flush_esr(rv); flush_esr(rv);
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h030, 32'h0);
        rd(12'h020, rv); chk("R6 id unchanged", rv, 32'h5A00_0000);
        rd(12'h030, rv); chk("R6 version unchanged", rv, 32'h0005_0014);
        flush_esr(rv); chk("R6 no error", rv, 0);
        wr(12'h0A0, 32'hFF);
        flush_esr(rv); chk("R7 ppr write error", rv, 32'h80);
        wr(12'h150, 32'hFFFF_FFFF);
        rd(12'h150, rv); chk("R7 isr unchanged", rv, 32'h1000_0005);
        flush_esr(rv); chk("R7 isr write error", rv, 32'h80);
        wr(12'h390, 32'h1234);
        rd(12'h390, rv); chk("R7 ccr unchanged", rv, 32'h0BAD_F00D);
        flush_esr(rv); chk("R7 ccr write error", rv, 32'h80);
    endtask

    task automatic t_esr_events;
        flush_esr(rv); flush_esr(rv);
        @(negedge clk); err_evt_i = 8'h04;
        @(negedge clk); err_evt_i = 8'h00;
        rd(12'h280, rv); chk("R8 not visible before flush", rv, 0);
        flush_esr(rv); chk("R8 event visible", rv, 32'h04);
        rd(12'h280, rv); chk("R8 held", rv, 32'h04);
    endtask

    task automatic t_lvt_svr;
        wr(12'h320, 32'h0002_00AB);
        rd(12'h320, rv); chk("R9 forced mask", rv, 32'h0003_00AB);
        wr(12'h0F0, 32'hFFFF_FFFF);
        rd(12'h0F0, rv); chk("R10 svr kept bits", rv, 32'h0000_03FF);
        chk("R10 sw_en", 32'(sw_en_o), 1);
        wr(12'h320, 32'h0002_00AB);
        rd(12'h320, rv); chk("R9 timer enabled", rv, 32'h0002_00AB);
        wr(12'h330, 32'hFFFF_FFFF);
        rd(12'h330, rv); chk("R9 thermal mask", rv, 32'h0001_07FF);
        wr(12'h350, 32'hFFFF_FFFF);
        rd(12'h350, rv); chk("R9 pin0 mask", rv, 32'h0001_A7FF);
        wr(12'h370, 32'h0000_FFFF);
        rd(12'h370, rv); chk("R9 error entry mask", rv, 32'h0000_00FF);
        wr(12'h0F0, 32'h0000_00FF);
        rd(12'h320, rv); chk("R10 timer masked", rv, 32'h0003_00AB);
        rd(12'h370, rv); chk("R10 error masked", rv, 32'h0001_00FF);
        chk("R10 lvt_o timer", lvt_o[31:0], 32'h0003_00AB);
    endtask

    task automatic t_masks;
        wr(12'h0E0, 32'h0);
        rd(12'h0E0, rv); chk("R11 dfr ones", rv, 32'h0FFF_FFFF);
        wr(12'h0D0, 32'hFFFF_FFFF);
        rd(12'h0D0, rv); chk("R11 ldr", rv, 32'hFF00_0000);
        wr(12'h080, 32'h1234_5678);
        rd(12'h080, rv); chk("R11 tpr", rv, 32'h78);
        chk("R11 tpr_o", 32'(tpr_o), 32'h78);
        wr(12'h3E0, 32'hFF);
        rd(12'h3E0, rv); chk("R11 divide", rv, 32'hB);
        wr(12'h380, 32'hDEAD_BEEF);
        rd(12'h380, rv); chk("R11 initial count", rv, 32'hDEAD_BEEF);
        chk("R11 timer_init_o", timer_init_o, 32'hDEAD_BEEF);
    endtask

    task automatic t_icr;
        wr(12'h310, 32'hFFFF_FFFF);
        chk("R12 no strobe on high", 32'(ipi_snap), 0);
        rd(12'h310, rv); chk("R12 high dest", rv, 32'hFF00_0000);
        wr(12'h300, 32'hFFFF_FFFF);
        chk("R12 strobe", 32'(ipi_snap), 1);
        @(posedge clk); #1;
        chk("R12 strobe one cycle", 32'(ipi_send_o), 0);
        rd(12'h300, rv); chk("R12 low mask", rv, 32'h000C_CFFF);
        chk("R12 icr_o", icr_o[63:32], 32'hFF00_0000);
    endtask

    task automatic t_eoi;
        wr(12'h0B0, 32'h55);
        chk("R13 eoi strobe", 32'(eoi_snap), 1);
        @(posedge clk); #1;
        chk("R13 eoi one cycle", 32'(eoi_o), 0);
        rd(12'h0B0, rv); chk("R13 eoi readback", rv, 32'h55);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_live();
        t_illegal();
        t_readonly();
        t_esr_events();
        t_lvt_svr();
        t_masks();
        t_icr();
        t_eoi();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule